// File: doc/BRIEF.md
# Serial Port Crossbar Router

This block connects three host-side serial ports to four device-side serial links. The host ports are two asynchronous-controller ports (A and B) and one bit-banged serial/printer port. One 8-bit read/write configuration byte holds a 2-bit device number for each host port and two baud-doubling flags. Each host port's transmit line goes to the device it selects, and that device's receive line comes back to the host port. Device 0 does not exist as a physical link. It is a discard sink: anything sent to it is dropped, and a host routed to it sees a receive line that stays idle.

More than one host may select the same device. In that case, device transmit ownership follows a fixed priority: port A first, then port B, then the bit-banged port. Every host still receives from the device it selected. The two doubling flags are passed straight out as configuration for the baud generators of devices 1 and 2. The routing paths are combinational from the configuration register, so they add no latency on the serial data.

Top module: `serial_xbar`

## Requirements
- R1: After a synchronous reset the configuration byte reads 0x00. In that state all host receive lines and all device transmit lines are high, and both doubling outputs are 0.
- R2: A write of `cfg_wdata` with `cfg_we` high is stored at the clock edge and reads back unchanged on `cfg_rdata`. The byte is unchanged while `cfg_we` is low.
- R3: Field positions are fixed. Bits 7..6 hold the device for host 0 (port A). Bits 5..4 hold the device for host 1 (port B). Bits 3..2 hold the device for host 2 (the bit-banged port).
- R4: A host whose field holds a nonzero device d has `host_rx` equal to `dev_rx[d]`.
- R5: A host whose field holds 0 has its `host_rx` held at 1. Its `host_tx` reaches no device transmit line.
- R6: `dev_tx[0]` is always 1, and `dev_rx[0]` affects no output.
- R7: A device d ≠ 0 selected by several hosts has its `dev_tx[d]` driven by the lowest-numbered of those hosts (priority host 0, then 1, then 2).
- R8: A device d ≠ 0 that no host selects has its `dev_tx[d]` held at 1.
- R9: `baud_dbl[0]` equals configuration bit 0 (device 1 doubler). `baud_dbl[1]` equals bit 1 (device 2 doubler).
- R10: A new configuration takes effect on all outputs right after the clock edge that stores it, and not before that edge.
- R11: Configuration 0x24 routes host 0 to device 0, host 1 to device 2 and host 2 to device 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte to write |
| cfg_rdata | output | 8 | Current configuration byte |
| host_tx | input | 3 | Transmit lines of hosts 0 (A), 1 (B), 2 (bit-banged) |
| host_rx | output | 3 | Receive lines to the hosts |
| dev_tx | output | 4 | Transmit lines to devices 0..3 (bit 0 is the sink, held high) |
| dev_rx | input | 4 | Receive lines from devices 0..3 (bit 0 ignored) |
| baud_dbl | output | 2 | Baud-doubling flags: bit 0 for device 1, bit 1 for device 2 |

## Verification
The router is exercised under several distinct configurations:
- Three disjoint one-to-one mappings, including 0x24, which separate a field-position mix-up from a data-path fault.
- Configurations where all hosts select one device, or two hosts share one, which expose the transmit priority order.
- Configurations that park hosts on the sink, which show discard and idle receive.

Under each configuration, walking-one and walking-zero patterns are applied to the host transmit and device receive lines, so a swapped or stuck connection gives a wrong bit. A check just before and just after each write edge tells a registered configuration apart from one that leaks through early.

// File: rtl/sxb_pkg.sv
package sxb_pkg;
  localparam int unsigned SXB_NUM_HOST = 3;
  localparam int unsigned SXB_NUM_DEV  = 4;
  localparam int unsigned SXB_SEL_W    = $clog2(SXB_NUM_DEV);
  localparam int unsigned SXB_CFG_W    = 8;
  localparam int unsigned SXB_DBL_W    = 2;

  // lowest bit of the device field of host h; host 0 takes the top field
  function automatic int unsigned field_lsb(input int unsigned cfg_w,
                                            input int unsigned sel_w,
                                            input int unsigned h);
    return cfg_w - sel_w * (h + 1);
  endfunction
endpackage

// File: rtl/sxb_cfg_reg.sv
module sxb_cfg_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> q == '0);
  p_write_store_r2: assert property (@(posedge clk) disable iff (rst)
                                     we |=> q == $past(wdata));
  p_write_hold_r2:  assert property (@(posedge clk) disable iff (rst)
                                     !we |=> $stable(q));
endmodule

// File: rtl/sxb_rx_sel.sv
module sxb_rx_sel #(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned SEL_W   = $clog2(NUM_DEV)
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_DEV-1:0] dev_rx,
  output logic               host_rx
);
  // device 0 is the discard sink: its receive pin is never looked at
  always_comb begin
    if (sel == '0) host_rx = 1'b1;
    else           host_rx = dev_rx[sel];
  end
endmodule

// File: rtl/sxb_tx_arb.sv
module sxb_tx_arb #(
  parameter int unsigned NUM_HOST = 3,
  parameter int unsigned NUM_DEV  = 4,
  parameter int unsigned SEL_W    = $clog2(NUM_DEV)
) (
  input  logic [NUM_HOST*SEL_W-1:0] sel_flat,
  input  logic [NUM_HOST-1:0]       host_tx,
  output logic [NUM_DEV-1:0]        dev_tx
);
  // sink line is a fixed idle level
  assign dev_tx[0] = 1'b1;

  for (genvar d = 1; d < NUM_DEV; d++) begin : g_dev
    logic hit_any;
    logic line;
    always_comb begin
      hit_any = 1'b0;
      line    = 1'b1;
      // scan from lowest priority upward; host 0 overrides last
      for (int h = NUM_HOST - 1; h >= 0; h--) begin
        if (sel_flat[h*SEL_W +: SEL_W] == SEL_W'(d)) begin
          hit_any = 1'b1;
          line    = host_tx[h];
        end
      end
    end
    assign dev_tx[d] = hit_any ? line : 1'b1;
  end
endmodule

// File: rtl/serial_xbar.sv
module serial_xbar
  import sxb_pkg::*;
#(
  parameter int unsigned NUM_HOST = SXB_NUM_HOST,
  parameter int unsigned NUM_DEV  = SXB_NUM_DEV,
  parameter int unsigned CFG_W    = SXB_CFG_W,
  parameter int unsigned DBL_W    = SXB_DBL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  input  logic [NUM_HOST-1:0] host_tx,
  output logic [NUM_HOST-1:0] host_rx,
  output logic [NUM_DEV-1:0]  dev_tx,
  input  logic [NUM_DEV-1:0]  dev_rx,
  output logic [DBL_W-1:0]    baud_dbl
);
  localparam int unsigned SEL_W = $clog2(NUM_DEV);

  logic [CFG_W-1:0]          cfg_q;
  logic [NUM_HOST*SEL_W-1:0] sel_flat;

  sxb_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (cfg_q)
  );

  assign cfg_rdata = cfg_q;
  assign baud_dbl  = cfg_q[DBL_W-1:0];

  for (genvar h = 0; h < NUM_HOST; h++) begin : g_host
    localparam int unsigned LSB = field_lsb(CFG_W, SEL_W, h);
    logic [SEL_W-1:0] sel;
    assign sel = cfg_q[LSB +: SEL_W];
    assign sel_flat[h*SEL_W +: SEL_W] = sel;

    sxb_rx_sel #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_rx (
      .sel     (sel),
      .dev_rx  (dev_rx),
      .host_rx (host_rx[h])
    );

    // receive path follows the selected device (R4)
    p_rx_follow_r4: assert property (@(posedge clk) disable iff (rst)
      (sel != '0) |-> host_rx[h] == dev_rx[sel]);
    // a host parked on the sink hears idle (R5)
    p_rx_idle_r5: assert property (@(posedge clk) disable iff (rst)
      (sel == '0) |-> host_rx[h]);
  end

  sxb_tx_arb #(.NUM_HOST(NUM_HOST), .NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_tx (
    .sel_flat (sel_flat),
    .host_tx  (host_tx),
    .dev_tx   (dev_tx)
  );

  // highest-priority host owns a device; unclaimed devices idle (R7, R8)
  for (genvar d = 1; d < NUM_DEV; d++) begin : g_chk
    logic [NUM_HOST-1:0] claim;
    for (genvar h = 0; h < NUM_HOST; h++) begin : g_c
      assign claim[h] = (cfg_q[field_lsb(CFG_W, SEL_W, h) +: SEL_W] == SEL_W'(d));
    end
    p_first_claim_r7: assert property (@(posedge clk) disable iff (rst)
      claim[0] |-> dev_tx[d] == host_tx[0]);
    p_second_claim_r7: assert property (@(posedge clk) disable iff (rst)
      (!claim[0] && claim[1]) |-> dev_tx[d] == host_tx[1]);
    p_unclaimed_idle_r8: assert property (@(posedge clk) disable iff (rst)
      (claim == '0) |-> dev_tx[d]);
  end

  // output follows the stored byte, not the write data (R10)
  p_cfg_timing_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> baud_dbl == $past(cfg_wdata[DBL_W-1:0]));
endmodule

// File: tb/test_serial_xbar.sv
module test_serial_xbar;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [2:0] host_tx = 3'b111;
  logic [2:0] host_rx;
  logic [3:0] dev_tx;
  logic [3:0] dev_rx = 4'b1111;
  logic [1:0] baud_dbl;

  always #5 clk = ~clk;

  serial_xbar i_serial_xbar (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .host_tx(host_tx), .host_rx(host_rx),
    .dev_tx(dev_tx), .dev_rx(dev_rx), .baud_dbl(baud_dbl)
  );

  typedef struct {
    logic [7:0] rd;
    logic [2:0] hrx;
    logic [3:0] dtx;
    logic [1:0] dbl;
    string      tag;
  } exp_t;

  exp_t queue_q[$];
  event go;
  int   n_run  = 0;
  int   n_fail = 0;
  logic [7:0] model_cfg = 8'h00;
  bit   done = 0;

  // reference from the requirements: fields at 7..6, 5..4, 3..2; device 0 sink
  function automatic exp_t predict(logic [7:0] c, logic [2:0] htx,
                                   logic [3:0] drx, string tag);
    exp_t e;
    e.rd  = c;
    e.dbl = c[1:0];
    e.dtx = 4'b1111;
    e.tag = tag;
    for (int h = 0; h < 3; h++) begin
      logic [1:0] s;
      s = c[7-2*h -: 2];
      e.hrx[h] = (s == 2'd0) ? 1'b1 : drx[s];
    end
    for (int h = 2; h >= 0; h--) begin
      logic [1:0] s;
      s = c[7-2*h -: 2];
      if (s != 2'd0) e.dtx[s] = htx[h];
    end
    return e;
  endfunction

  task automatic check_field(string what, string tag, logic [7:0] act, logic [7:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // monitor: samples outputs 2 ns after the driver changes inputs
  initial begin
    forever begin
      @(go);
      #2;
      while (queue_q.size() > 0) begin
        exp_t e;
        e = queue_q.pop_front();
        check_field("cfg_rdata", e.tag, cfg_rdata, e.rd);
        check_field("host_rx", e.tag, {5'b0, host_rx}, {5'b0, e.hrx});
        check_field("dev_tx", e.tag, {4'b0, dev_tx}, {4'b0, e.dtx});
        check_field("baud_dbl", e.tag, {6'b0, baud_dbl}, {6'b0, e.dbl});
      end
    end
  end

  task automatic apply(logic [2:0] htx, logic [3:0] drx, string tag);
    @(negedge clk);
    host_tx = htx;
    dev_rx  = drx;
    queue_q.push_back(predict(model_cfg, htx, drx, tag));
    -> go;
    #3;
  endtask

  // write; just before the storing edge outputs must still show the old byte (R10)
  task automatic write_cfg(logic [7:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    queue_q.push_back(predict(model_cfg, host_tx, dev_rx, "R10_before"));
    -> go;
    #3;
    @(negedge clk);
    cfg_we = 1'b0;
    model_cfg = v;
    queue_q.push_back(predict(model_cfg, host_tx, dev_rx, "R2_R10_after"));
    -> go;
    #3;
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 3; i++) apply(3'b111 ^ (3'b001 << i), 4'b1111, tag);
    for (int i = 0; i < 3; i++) apply(3'b001 << i, 4'b0000, tag);
    for (int i = 0; i < 4; i++) apply(3'b000, 4'b0001 << i, tag);
    for (int i = 0; i < 4; i++) apply(3'b111, 4'b1111 ^ (4'b0001 << i), tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    apply(3'b000, 4'b0000, "R1_reset");      // all parked on sink
    apply(3'b101, 4'b0110, "R1_R5_R6");
    write_cfg(8'h24); sweep("R11_R3_R4");    // A->0, B->2, bitbang->1
    write_cfg(8'h90); sweep("R3_R4_R8");     // A->2, B->1, bitbang->0
    write_cfg(8'h60); sweep("R3_R5_R8");     // A->1, B->2
    write_cfg(8'hE4); sweep("R3_R4");        // A->3, B->2, bitbang->1
    write_cfg(8'hFC); sweep("R7_all");       // everyone on device 3
    write_cfg(8'h58); sweep("R7_pair");      // A->1, B->1, bitbang->2
    write_cfg(8'h0C); sweep("R7_R5");        // only bitbang->3
    write_cfg(8'h01); sweep("R9_dbl1");
    write_cfg(8'h02); sweep("R9_dbl2");
    write_cfg(8'h03); sweep("R9_both_R6");
    // write strobe low: byte must hold (R2)
    @(negedge clk); cfg_wdata = 8'hAA;
    apply(3'b010, 4'b1010, "R2_hold");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; model_cfg = 8'h00;
    apply(3'b000, 4'b0000, "R1_rereset");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule